// File: doc/BRIEF.md
# Guarded Vector-Table Select Register

This block holds one configuration bit that chooses where the interrupt vector table is based. A value of 0 places the table at the bottom of program memory. A value of 1 moves it into the boot area. A stray store must not flip the bit by accident, so the block accepts a new value only through a two-step sequence on one control register address:

1. A first write sets the unlock bit. This opens a short window.
2. A second write then arrives with the unlock bit cleared. It carries the wanted select value.

The window is a fixed number of clock cycles. It is set by `WINDOW`, which defaults to 4. If the window runs out, the unlock drops by itself and the sequence must start again.

Inside the block, a small controller has two named states, `ST_LOCKED` and `ST_OPEN`, and a down-counter tracks the open window. The named transitions are:

- **arm**: `ST_LOCKED` → `ST_OPEN`, on an unlock write. The counter is loaded.
- **rearm**: `ST_OPEN` → `ST_OPEN`, on another unlock write. The counter is reloaded.
- **commit**: `ST_OPEN` → `ST_LOCKED`, on a qualifying write. The select bit is updated.
- **tick**: `ST_OPEN` → `ST_OPEN`, on a cycle with no control write. The counter counts down.
- **expire**: `ST_OPEN` → `ST_LOCKED`, on the last window cycle with no control write.
- **hold**: `ST_LOCKED` → `ST_LOCKED`, on anything else.

Control register bit positions:

| Bit | Meaning |
|---|---|
| bit 0 | unlock |
| bit 1 | table select |

The address is `CTRL_ADDR`, default 6'h35. A control write is a cycle with `wr_en` high and `wr_addr` equal to `CTRL_ADDR`.

Top module: `cfgguard_top`

## Requirements
- R1: After reset, `tbl_sel_o` is 0 (table at start of program memory) and `unlock_o` is 0.
- R2: A control write with bit 0 = 1 makes `unlock_o` 1 from the next cycle on and leaves `tbl_sel_o` unchanged.
- R3: A control write with bit 0 = 0, sampled at any of the `WINDOW` clock edges that follow the enabling write, copies bit 1 into `tbl_sel_o` (1 selects the boot area) and clears `unlock_o` from the next cycle.
- R4: If no control write arrives during those `WINDOW` edges, `unlock_o` falls after the last of them. A later control write with bit 0 = 0 then leaves `tbl_sel_o` unchanged.
- R5: A control write with bit 0 = 0 while `unlock_o` is 0 leaves `tbl_sel_o` unchanged.
- R6: A control write with bit 0 = 1 while `unlock_o` is 1 restarts the full `WINDOW`-edge count from that write.
- R7: Writes to any other address, and cycles with `wr_en` low, neither change `tbl_sel_o` nor close or shorten an open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; bit 0 unlock, bit 1 table select |
| tbl_sel_o | output | 1 | Protected table-select bit |
| unlock_o | output | 1 | Unlock flag, high while the window is open |

## Verification
The bench commits on both the first and the last cycle of the window. A counter that is off by one would either refuse the last-cycle commit or still accept a commit one cycle after expiry.

It re-arms late in an open window and then commits beyond the original deadline. A design that ignores a re-arm would have already locked at that point.

It also writes to foreign addresses and drives control data with the strobe low while the window is open. A loose decoder would either end the window early or let the select bit change.

// File: rtl/cfgguard_pkg.sv
package cfgguard_pkg;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } guard_state_t;

    typedef enum logic [1:0] {
        WK_NONE   = 2'd0,
        WK_ARM    = 2'd1,
        WK_COMMIT = 2'd2
    } wr_kind_t;

endpackage

// File: rtl/cfgguard_decode.sv
module cfgguard_decode
    import cfgguard_pkg::*;
#(
    parameter int                ADDR_W     = 6,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 6'h35,
    parameter int                UNLOCK_BIT = 0,
    parameter int                SEL_BIT    = 1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_kind_t          kind_o,
    output logic              new_sel_o
);

    logic hit;

    assign hit       = wr_en && (wr_addr == CTRL_ADDR);
    assign new_sel_o = wr_data[SEL_BIT];

    always_comb begin
        if (!hit)
            kind_o = WK_NONE;
        else if (wr_data[UNLOCK_BIT])
            kind_o = WK_ARM;
        else
            kind_o = WK_COMMIT;
    end

endmodule

// File: rtl/cfgguard_window.sv
module cfgguard_window #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic dec_i,
    output logic last_o
);

    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] FULL = CW'(WINDOW);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load_i)
            remain <= FULL;
        else if (dec_i && remain != '0)
            remain <= remain - ONE;
    end

    assign last_o = (remain == ONE);

endmodule

// File: rtl/cfgguard_top.sv
module cfgguard_top
    import cfgguard_pkg::*;
#(
    parameter int                ADDR_W     = 6,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 6'h35,
    parameter int                UNLOCK_BIT = 0,
    parameter int                SEL_BIT    = 1,
    parameter int                WINDOW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tbl_sel_o,
    output logic              unlock_o
);

    wr_kind_t     kind;
    logic         new_sel;
    logic         win_last;
    logic         win_load;
    logic         win_dec;
    guard_state_t state_q, state_d;

    cfgguard_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR),
        .UNLOCK_BIT(UNLOCK_BIT),
        .SEL_BIT   (SEL_BIT)
    ) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .kind_o   (kind),
        .new_sel_o(new_sel)
    );

    cfgguard_window #(
        .WINDOW(WINDOW)
    ) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(win_load),
        .dec_i (win_dec),
        .last_o(win_last)
    );

    // next-state and counter control
    always_comb begin
        state_d  = state_q;
        win_load = 1'b0;
        win_dec  = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                if (kind == WK_ARM) begin          // arm
                    state_d  = ST_OPEN;
                    win_load = 1'b1;
                end
            end
            ST_OPEN: begin
                if (kind == WK_ARM) begin          // rearm
                    win_load = 1'b1;
                end else if (kind == WK_COMMIT) begin
                    state_d = ST_LOCKED;           // commit
                end else if (win_last) begin
                    state_d = ST_LOCKED;           // expire
                end else begin
                    win_dec = 1'b1;                // tick
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_LOCKED;
        else
            state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tbl_sel_o <= 1'b0;
        else if (state_q == ST_OPEN && kind == WK_COMMIT)
            tbl_sel_o <= new_sel;
    end

    assign unlock_o = (state_q == ST_OPEN);

endmodule

// File: rtl/cfgguard_chk.sv
module cfgguard_chk #(
    parameter int                ADDR_W     = 6,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 6'h35,
    parameter int                UNLOCK_BIT = 0,
    parameter int                SEL_BIT    = 1,
    parameter int                WINDOW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              tbl_sel_o,
    input logic              unlock_o
);

    localparam int AW = $clog2(WINDOW + 1) + 1;

    logic          ctl_wr, arm_wr, commit_wr;
    logic [AW-1:0] age;

    assign ctl_wr    = wr_en && (wr_addr == CTRL_ADDR);
    assign arm_wr    = ctl_wr && wr_data[UNLOCK_BIT];
    assign commit_wr = ctl_wr && !wr_data[UNLOCK_BIT];

    // edges elapsed since the most recent unlock write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age <= '0;
        else if (arm_wr)
            age <= '0;
        else if (unlock_o && age != '1)
            age <= age + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_STATE: assert (!tbl_sel_o && !unlock_o); // R1
        end
    end

    AST_ARM_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> unlock_o && $stable(tbl_sel_o)); // R2

    AST_COMMIT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_o && commit_wr |=> !unlock_o && tbl_sel_o == $past(wr_data[SEL_BIT])); // R3

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_o |-> age < AW'(WINDOW)); // R4

    AST_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_o && !ctl_wr && age == AW'(WINDOW - 1) |=> !unlock_o); // R4

    AST_LOCKED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock_o && commit_wr |=> $stable(tbl_sel_o)); // R5

    AST_REARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_o && arm_wr |=> unlock_o); // R6

    AST_FOREIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_o && !ctl_wr && age < AW'(WINDOW - 1) |=> unlock_o && $stable(tbl_sel_o)); // R7

endmodule

bind cfgguard_top cfgguard_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR),
    .UNLOCK_BIT(UNLOCK_BIT),
    .SEL_BIT   (SEL_BIT),
    .WINDOW    (WINDOW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tbl_sel_o(tbl_sel_o),
    .unlock_o (unlock_o)
);

// File: tb/sim_cfgguard_top.sv
module sim_cfgguard_top;

    localparam logic [5:0] CTRL  = 6'h35;
    localparam logic [5:0] OTHER = 6'h12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tbl_sel_o;
    logic       unlock_o;

    int n_checks = 0;
    int n_fails  = 0;

    cfgguard_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tbl_sel_o(tbl_sel_o),
        .unlock_o (unlock_o)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // all tasks start and end 1 time unit after a rising edge
    task automatic write(input logic [5:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic t_reset;
        check("R1 sel after reset", tbl_sel_o, 1'b0);
        check("R1 unlock after reset", unlock_o, 1'b0);
    endtask

    task automatic t_first_cycle_commit;
        write(CTRL, 8'h03);
        check("R2 unlock after arm", unlock_o, 1'b1);
        check("R2 sel unchanged by arm", tbl_sel_o, 1'b0);
        write(CTRL, 8'h02);
        check("R3 sel set on first window cycle", tbl_sel_o, 1'b1);
        check("R3 unlock cleared by commit", unlock_o, 1'b0);
    endtask

    task automatic t_last_cycle_commit;
        write(CTRL, 8'h01);
        idle(3);
        check("R3 unlock still open at last cycle", unlock_o, 1'b1);
        write(CTRL, 8'h00);
        check("R3 sel cleared on last window cycle", tbl_sel_o, 1'b0);
        check("R3 unlock cleared", unlock_o, 1'b0);
    endtask

    task automatic t_expire;
        write(CTRL, 8'h01);
        idle(4);
        check("R4 unlock dropped after window", unlock_o, 1'b0);
        write(CTRL, 8'h02);
        check("R4 late commit ignored", tbl_sel_o, 1'b0);
    endtask

    task automatic t_locked_ignore;
        write(CTRL, 8'h02);
        check("R5 locked write ignored (to 1)", tbl_sel_o, 1'b0);
        write(CTRL, 8'h01);
        write(CTRL, 8'h02);
        check("R3 sel set for R5 setup", tbl_sel_o, 1'b1);
        write(CTRL, 8'h00);
        check("R5 locked write ignored (to 0)", tbl_sel_o, 1'b1);
    endtask

    task automatic t_rearm;
        write(CTRL, 8'h01);
        idle(3);
        write(CTRL, 8'h01);
        idle(3);
        check("R6 window restarted by rearm", unlock_o, 1'b1);
        write(CTRL, 8'h00);
        check("R6 commit after restart", tbl_sel_o, 1'b0);
        write(CTRL, 8'h01);
        idle(2);
        write(CTRL, 8'h03);
        idle(4);
        check("R6 restarted window still expires", unlock_o, 1'b0);
        check("R6 sel unchanged by rearm", tbl_sel_o, 1'b0);
    endtask

    task automatic t_foreign;
        write(CTRL, 8'h01);
        write(OTHER, 8'h02);
        check("R7 other address keeps window", unlock_o, 1'b1);
        check("R7 other address keeps sel", tbl_sel_o, 1'b0);
        wr_en = 1'b0; wr_addr = CTRL; wr_data = 8'h02;
        @(posedge clk); #1;
        wr_addr = '0; wr_data = '0;
        check("R7 strobe low keeps sel", tbl_sel_o, 1'b0);
        check("R7 strobe low keeps window", unlock_o, 1'b1);
        write(CTRL, 8'h02);
        check("R7 commit after foreign cycles", tbl_sel_o, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_first_cycle_commit();
        t_last_cycle_commit();
        t_expire();
        t_locked_ignore();
        t_rearm();
        t_foreign();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule